// File: doc/BRIEF.md
# Battery Charge Counter with Full-Capacity Learning

This block tracks two 16-bit quantities for a battery gauge: the charge presently held in the cell (the nominal count) and the charge the cell held when last found full (the learned capacity). Both use one count per 3.57 µVh. An upstream integrator sends one sample per accumulation period on a valid/ready stream. Each sample carries an unsigned charge magnitude and four flags: the direction (charging or discharging), whether the cell voltage is above the final empty threshold, whether the first end-of-discharge threshold has been reached, and whether learning is still allowed.

A learning cycle starts when a discharge begins on a full cell, meaning the nominal count equals the learned capacity. The block then adds up the charge actually removed. If the first end-of-discharge flag arrives and learning stayed allowed for the whole discharge, the cycle completes. The learned capacity is then rewritten as the charge removed, plus one sixteenth of the design capacity, plus a compensation reduction. Design capacity and compensation reduction are plain inputs.

The block accepts a sample on any edge where `in_valid` and `in_ready` are both high. It lowers `in_ready` for exactly one cycle, the commit cycle in which the learned capacity is written, and raises it again on the next edge. A producer may hold `in_valid` and its sample steady across that cycle. A host reads both values through byte-wide read-only registers.

Top module: `coulomb_learn`

## Requirements
- R1: `in_ready` is high at all times except in the single cycle that follows the edge on which a learning cycle completes. During that cycle no sample is accepted, and any change to the learned capacity happens only at the edge that ends it.
- R2: An accepted charging sample (`in_chg`=1) adds `in_amt` to the nominal count only when `in_above_empty` is 1. When `in_above_empty` is 0, the nominal count is unchanged.
- R3: The nominal count saturates. Charging stops at the learned capacity, and discharging stops at zero. It never wraps.
- R4: A synchronous reset with `ram_bad`=1 clears the nominal count and loads the learned capacity with `design_cap`. A reset with `ram_bad`=0 keeps both values unchanged.
- R5: A learning cycle starts on an accepted discharging sample with `in_lrn_ok`=1, taken while idle, when the nominal count before the sample equals the learned capacity.
- R6: The cycle completes on an accepted discharging sample with `in_lrn_ok`=1 and `in_edv1`=1; the starting sample may itself complete it. The charge removed is the sum of the actual drops in the nominal count, including the first and last samples. At commit, the learned capacity becomes removed + (`design_cap` >> 4) + `comp_red`, saturated to all ones.
- R7: An accepted charging sample, or an accepted sample with `in_lrn_ok`=0, during an active cycle aborts the cycle. The learned capacity is left unchanged.
- R8: At commit, if the nominal count exceeds the new learned capacity, it is clamped down to that capacity.
- R9: `rd_en` with `rd_addr` puts one byte on `rd_data` one cycle later. The addresses are: 0 = nominal low byte, 1 = nominal high byte, 2 = learned low byte, 3 = learned high byte. Reading a low byte captures that register's high byte into its own shadow. Reading a high byte returns the shadow. Reset clears `rd_data` and both shadows.
- R10: While no sample is accepted and no commit occurs, the nominal count holds regardless of the flag inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ram_bad | input | 1 | Storage-corruption flag, sampled during reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample ready, low only in the commit cycle |
| in_amt | input | AW | Charge magnitude of the sample |
| in_chg | input | 1 | 1 = charging, 0 = discharging |
| in_above_empty | input | 1 | Cell voltage above the final empty threshold |
| in_edv1 | input | 1 | First end-of-discharge threshold reached |
| in_lrn_ok | input | 1 | Learning still allowed |
| design_cap | input | CW | Design capacity |
| comp_red | input | CW | Compensation reduction added at commit |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host byte address |
| rd_data | output | CW/2 | Host read data, registered |

## Verification
The bench builds the block with CW=16 and AW=4. A 4-bit magnitude lets the bench sweep every sample amount with the voltage flag both low and high. It also makes every charge and discharge small next to a 400-count capacity, so both saturation edges, the crossing of a byte boundary for the shadow reads, and the commit clamp are each reached within a few dozen samples. A large `comp_red` drives the commit sum past 16 bits to exercise saturation of the learned capacity.

// File: rtl/coulomb_learn_pkg.sv
package coulomb_learn_pkg;
  typedef enum logic [1:0] {
    LS_IDLE   = 2'd0,
    LS_RUN    = 2'd1,
    LS_COMMIT = 2'd2
  } lstate_e;
endpackage

// File: rtl/cl_nominal.sv
module cl_nominal #(
  parameter int CW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ram_bad,
  input  logic          acc,
  input  logic          chg,
  input  logic          above,
  input  logic [AW-1:0] amt,
  input  logic [CW-1:0] lmd,
  input  logic          clamp_en,
  input  logic [CW-1:0] clamp_val,
  output logic [CW-1:0] nac,
  output logic [CW-1:0] dec
);
  logic [CW-1:0] amt_w;
  logic [CW:0]   sum;
  logic [CW-1:0] up_val;
  logic [CW-1:0] dn_val;

  always_comb begin
    amt_w  = CW'(amt);
    sum    = {1'b0, nac} + {1'b0, amt_w};
    up_val = (sum > {1'b0, lmd}) ? lmd : sum[CW-1:0];
    dn_val = (amt_w > nac) ? '0 : nac - amt_w;
    dec    = chg ? '0 : ((amt_w > nac) ? nac : amt_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ram_bad) nac <= '0;
    end else if (clamp_en) begin
      if (nac > clamp_val) nac <= clamp_val;
    end else if (acc) begin
      if (chg) begin
        if (above) nac <= up_val;
      end else begin
        nac <= dn_val;
      end
    end
  end
endmodule

// File: rtl/cl_learn.sv
module cl_learn
  import coulomb_learn_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ram_bad,
  input  logic          acc,
  input  logic          chg,
  input  logic          edv1,
  input  logic          lrn_ok,
  input  logic          full,
  input  logic [CW-1:0] dec,
  input  logic [CW-1:0] design_cap,
  input  logic [CW-1:0] comp_red,
  output logic [CW-1:0] lmd,
  output logic [CW-1:0] lmd_next,
  output lstate_e       state
);
  localparam int TW = CW + 2;

  logic [CW-1:0] removed;
  logic [TW-1:0] total;

  always_comb begin
    total    = TW'(removed) + TW'(design_cap >> 4) + TW'(comp_red);
    lmd_next = (|total[TW-1:CW]) ? '1 : total[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LS_IDLE;
      removed <= '0;
      if (ram_bad) lmd <= design_cap;
    end else begin
      unique case (state)
        LS_IDLE: begin
          if (acc && !chg && lrn_ok && full) begin
            removed <= dec;
            state   <= edv1 ? LS_COMMIT : LS_RUN;
          end
        end
        LS_RUN: begin
          if (acc) begin
            if (chg || !lrn_ok) begin
              state <= LS_IDLE;
            end else begin
              removed <= removed + dec;
              if (edv1) state <= LS_COMMIT;
            end
          end
        end
        LS_COMMIT: begin
          lmd   <= lmd_next;
          state <= LS_IDLE;
        end
        default: state <= LS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cl_hostregs.sv
module cl_hostregs #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  input  logic [CW-1:0] val0,
  input  logic [CW-1:0] val1,
  output logic [CW/2-1:0] rd_data
);
  localparam int HW = CW / 2;
  localparam int NREG = 2;

  logic [CW-1:0] vals [NREG];
  logic [HW-1:0] shadow [NREG];

  assign vals[0] = val0;
  assign vals[1] = val1;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [HW-1:0] sh_q;
    logic          lo_hit;
    assign lo_hit = rd_en && !rd_addr[0] && (32'(rd_addr[1]) == g);
    always_ff @(posedge clk) begin
      if (rst)         sh_q <= '0;
      else if (lo_hit) sh_q <= vals[g][CW-1:HW];
    end
    assign shadow[g] = sh_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_addr[0] ? shadow[rd_addr[1]] : vals[rd_addr[1]][HW-1:0];
    end
  end
endmodule

// File: rtl/coulomb_learn.sv
module coulomb_learn
  import coulomb_learn_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ram_bad,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_amt,
  input  logic          in_chg,
  input  logic          in_above_empty,
  input  logic          in_edv1,
  input  logic          in_lrn_ok,
  input  logic [CW-1:0] design_cap,
  input  logic [CW-1:0] comp_red,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [CW/2-1:0] rd_data
);
  logic [CW-1:0] nac_q;
  logic [CW-1:0] lmd_q;
  logic [CW-1:0] lmd_next;
  logic [CW-1:0] dec;
  lstate_e       st;
  logic          acc;
  logic          commit;

  assign commit   = (st == LS_COMMIT);
  assign in_ready = !commit;
  assign acc      = in_valid && in_ready;

  cl_nominal #(.CW(CW), .AW(AW)) u_nominal (
    .clk(clk), .rst(rst), .ram_bad(ram_bad), .acc(acc),
    .chg(in_chg), .above(in_above_empty), .amt(in_amt), .lmd(lmd_q),
    .clamp_en(commit), .clamp_val(lmd_next), .nac(nac_q), .dec(dec)
  );

  cl_learn #(.CW(CW)) u_learn (
    .clk(clk), .rst(rst), .ram_bad(ram_bad), .acc(acc), .chg(in_chg),
    .edv1(in_edv1), .lrn_ok(in_lrn_ok), .full(nac_q == lmd_q), .dec(dec),
    .design_cap(design_cap), .comp_red(comp_red), .lmd(lmd_q),
    .lmd_next(lmd_next), .state(st)
  );

  cl_hostregs #(.CW(CW)) u_host (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .val0(nac_q), .val1(lmd_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/coulomb_learn_chk.sv
module coulomb_learn_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          acc,
  input logic          in_ready,
  input logic          in_chg,
  input logic          in_above,
  input logic [CW-1:0] nac,
  input logic [CW-1:0] lmd
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  assert_nac_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    !was_rst |-> nac <= lmd);

  assert_no_gain_below_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && in_chg && !in_above) |=> nac == $past(nac));

  assert_discharge_no_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_chg) |=> nac <= $past(nac));

  assert_single_stall_R1: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && !in_ready) |=> in_ready);

  assert_lmd_after_stall_R1: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && lmd != $past(lmd)) |-> !$past(in_ready));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!acc && in_ready) |=> nac == $past(nac));
endmodule

bind coulomb_learn coulomb_learn_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .acc(in_valid & in_ready), .in_ready(in_ready),
  .in_chg(in_chg), .in_above(in_above_empty), .nac(nac_q), .lmd(lmd_q)
);

// File: tb/coulomb_learn_bench.sv
module coulomb_learn_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int AW = 4;

  logic clk = 0, rst = 1, ram_bad = 1;
  logic in_valid = 0, in_chg = 0, in_above_empty = 0, in_edv1 = 0, in_lrn_ok = 0;
  logic [AW-1:0] in_amt = '0;
  logic [CW-1:0] design_cap = 16'd400, comp_red = '0;
  logic rd_en = 0;
  logic [1:0] rd_addr = '0;
  logic in_ready;
  logic [CW/2-1:0] rd_data;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  int m_nac, m_lmd, m_st, m_rem, m_rd;
  int m_sh [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  coulomb_learn #(.CW(CW), .AW(AW)) u_coulomb_learn (
    .clk(clk), .rst(rst), .ram_bad(ram_bad), .in_valid(in_valid),
    .in_ready(in_ready), .in_amt(in_amt), .in_chg(in_chg),
    .in_above_empty(in_above_empty), .in_edv1(in_edv1), .in_lrn_ok(in_lrn_ok),
    .design_cap(design_cap), .comp_red(comp_red), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Reference model built from the requirements
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      if (ram_bad) begin m_nac = 0; m_lmd = int'(design_cap); end
      m_st = 0; m_rem = 0; m_rd = 0; m_sh[0] = 0; m_sh[1] = 0;
    end else begin
      int dec, s, nl;
      bit full;
      if (m_st == 2) begin
        nl = m_rem + (int'(design_cap) >> 4) + int'(comp_red);
        if (nl > 65535) nl = 65535;
        m_lmd = nl;
        if (m_nac > m_lmd) m_nac = m_lmd;
        m_st = 0;
      end else if (in_valid) begin
        full = (m_nac == m_lmd);
        dec = 0;
        if (in_chg) begin
          if (in_above_empty) begin
            s = m_nac + int'(in_amt);
            m_nac = (s > m_lmd) ? m_lmd : s;
          end
        end else begin
          dec = (int'(in_amt) > m_nac) ? m_nac : int'(in_amt);
          m_nac = m_nac - dec;
        end
        if (m_st == 0) begin
          if (!in_chg && in_lrn_ok && full) begin
            m_rem = dec;
            m_st = in_edv1 ? 2 : 1;
          end
        end else begin
          if (in_chg || !in_lrn_ok) m_st = 0;
          else begin
            m_rem = m_rem + dec;
            if (in_edv1) m_st = 2;
          end
        end
      end
      if (rd_en) begin
        int v;
        v = rd_addr[1] ? m_lmd : m_nac;
        if (!rd_addr[0]) begin
          m_rd = v & 255;
          m_sh[rd_addr[1]] = (v >> 8) & 255;
        end else begin
          m_rd = m_sh[rd_addr[1]];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit bad);
    @(negedge clk);
    rst = 1; ram_bad = bad;
    @(negedge clk);
    rst = 0; ram_bad = 0;
  endtask

  task automatic send(input int amt, input bit chg, input bit above,
                      input bit edv1, input bit ok, input bit keep);
    @(negedge clk);
    in_valid = 1; in_amt = AW'(amt); in_chg = chg;
    in_above_empty = above; in_edv1 = edv1; in_lrn_ok = ok;
    if (m_st == 2) begin
      chk(in_ready == 0, "R1 stall", int'(in_ready), 0);
      @(negedge clk);
    end
    chk(in_ready == 1, "R1 ready", int'(in_ready), 1);
    @(posedge clk);
    if (!keep) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic rd(input int addr, output int v);
    @(negedge clk);
    rd_en = 1; rd_addr = 2'(addr);
    @(negedge clk);
    rd_en = 0;
    v = int'(rd_data);
    chk(v == m_rd, "R9 byte", v, m_rd);
  endtask

  task automatic rd16(input int which, output int v);
    int lo, hi;
    rd(which * 2, lo);
    rd(which * 2 + 1, hi);
    v = hi * 256 + lo;
  endtask

  task automatic fill();
    while (m_nac != m_lmd) send(15, 1, 1, 0, 1, 0);
  endtask

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, w;
    do_reset(1);
    // R4 / R9: reset state
    chk(rd_data == 0, "R9 reset rd_data", int'(rd_data), 0);
    rd16(0, v); chk(v == 0, "R4 nac cleared", v, 0);
    rd16(1, v); chk(v == 400, "R4 lmd loaded", v, 400);

    // R2: sweep every amount with the voltage flag low, then high
    for (int a = 0; a < 16; a++) begin
      send(a, 1, 0, 0, 1, 0);
      rd16(0, v); chk(v == m_nac, "R2 below-empty charge", v, m_nac);
    end
    chk(m_nac == 0, "R2 no gain", m_nac, 0);
    for (int a = 0; a < 16; a++) begin
      send(a, 1, 1, 0, 1, 0);
      rd16(0, v); chk(v == m_nac, "R2 charge", v, m_nac);
    end
    chk(v == 120, "R2 charge sum", v, 120);

    // R9: shadow across a byte boundary
    while (m_nac < 250) send(10, 1, 1, 0, 1, 0);
    rd(0, v); chk(v == 250, "R9 low", v, 250);
    send(15, 1, 1, 0, 1, 0);
    rd(1, v); chk(v == 0, "R9 shadow held", v, 0);
    rd(0, v); chk(v == 9, "R9 low new", v, 9);
    rd(1, v); chk(v == 1, "R9 high new", v, 1);

    // R3: charge saturates at learned capacity
    fill();
    send(15, 1, 1, 0, 1, 0);
    rd16(0, v); chk(v == 400, "R3 upper saturation", v, 400);

    // R4: reset without corruption keeps values
    do_reset(0);
    rd16(0, v); chk(v == 400, "R4 nac retained", v, 400);
    rd16(1, v); chk(v == 400, "R4 lmd retained", v, 400);

    // R5/R6/R8/R1: full learning cycle, commit with back-pressure
    comp_red = 16'd7;
    for (int a = 1; a < 16; a++) send(a, 0, 1, 0, 1, 0);
    send(10, 0, 1, 1, 1, 1);
    send(2, 0, 1, 0, 1, 0);
    rd16(1, v); chk(v == 162, "R6 learned capacity", v, 162);
    rd16(0, v); chk(v == 160, "R8 clamp then discharge", v, 160);

    // R7: abort by charging
    fill();
    send(5, 0, 1, 0, 1, 0);
    send(3, 1, 1, 0, 1, 0);
    send(5, 0, 1, 1, 1, 0);
    rd16(1, v); chk(v == 162, "R7 charge abort", v, 162);
    // R7: abort by learning-not-allowed
    fill();
    send(5, 0, 1, 0, 1, 0);
    send(5, 0, 1, 0, 0, 0);
    send(5, 0, 1, 1, 1, 0);
    rd16(1, v); chk(v == 162, "R7 lrn_ok abort", v, 162);
    // R5: not full, so no start
    send(4, 0, 1, 1, 1, 0);
    rd16(1, v); chk(v == 162, "R5 no start when not full", v, 162);

    // R6: saturation of learned capacity, cycle completed on start sample
    fill();
    comp_red = 16'hFFF0;
    send(4, 0, 1, 1, 1, 0);
    rd16(1, v); chk(v == 65535, "R6 saturated sum", v, 65535);
    rd16(0, v); chk(v == 158, "R8 no clamp needed", v, 158);
    comp_red = 16'd0;

    // R3: discharge saturates at zero
    while (m_nac > 0) send(15, 0, 1, 0, 0, 0);
    send(15, 0, 1, 0, 0, 0);
    rd16(0, v); chk(v == 0, "R3 lower saturation", v, 0);

    // R10: idle inputs toggling without valid
    send(9, 1, 1, 0, 1, 0);
    rd16(0, w);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 0; in_amt = AW'(i); in_chg = i[0]; in_above_empty = i[1];
      in_edv1 = i[2]; in_lrn_ok = i[0];
    end
    rd16(0, v); chk(v == w && v == 9, "R10 idle hold", v, 9);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule